// File: doc/BRIEF.md
# TDM Audio Bus Listener

This block is a passive observer on a shared time-division-multiplexed serial audio bus. An external master drives the bit clock, the frame clock and one data line that carries eight audio channels, one 24-bit sample per slot. The listener never drives any of these lines. It brings all three into the system clock domain through two-flop synchronisers and finds rising bit-clock edges. It recovers frame alignment from the frame clock, assembles each slot MSB first and forwards every sample as one beat of a valid/ready stream for a stream-to-memory DMA channel.

Each beat is a 32-bit word. Bits 23:0 carry the sample, bits 26:24 the slot index, and bits 31:27 are always zero. The last-beat flag marks slot 7. The word has the same layout whatever board type feeds the bus, so software sees one receive format.

Back-pressure rules: a beat that is offered stays on the output, unchanged, until it is accepted. Up to two beats are held in a skid buffer. A sample that completes while both entries are occupied and no beat leaves in that cycle is discarded. A sticky overflow flag records the loss. Slot counting goes on unchanged, so the following samples keep their correct slot numbers.

Top module: `tdm_bus_listener`

## Requirements
- R1: After reset, m_tvalid, ovf_flag and frame_err are all 0.
- R2: A frame starts when the frame clock, sampled on rising bit-clock edges, goes from 0 to 1. The first data bit of slot 0 is taken on the next rising bit-clock edge. Slots follow back to back, 24 bits each, MSB first, and each sample appears in m_tdata[23:0].
- R3: m_tdata[26:24] holds the slot index, 0 to 7 in arrival order, and m_tdata[31:27] is 0.
- R4: m_tlast is 1 on the slot-7 beat and 0 on every other beat.
- R5: While m_tvalid is 1 and m_tready is 0, m_tvalid stays 1 and m_tdata and m_tlast do not change.
- R6: The output buffer holds two beats. A sample that completes when both are occupied and none leaves in that cycle is dropped, and ovf_flag then goes to 1 and stays 1 until reset.
- R7: After samples are dropped, the next full frame is delivered complete, with correct slot indices and data.
- R8: A frame-clock rise before all 8 slots of the current frame are complete produces a one-cycle pulse on frame_err and restarts slot counting at slot 0. A rise after slot 7 is complete produces no pulse.
- R9: Bits before the first frame-clock rise, and bits after slot 7 and before the next rise, produce no beats.
- R10: Bit clocks up to one quarter of the system clock are received correctly, with high and low phases of at least two system cycles each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_bclk | input | 1 | Bus bit clock, observed only |
| bus_fclk | input | 1 | Bus frame clock, observed only |
| bus_data | input | 1 | Shared serial data line |
| m_tdata | output | 32 | Beat word: sample, slot index, zero padding |
| m_tvalid | output | 1 | Beat offered |
| m_tready | input | 1 | Downstream accepts the beat |
| m_tlast | output | 1 | Beat is slot 7, the end of a frame |
| ovf_flag | output | 1 | Sticky flag: at least one sample was dropped |
| frame_err | output | 1 | One-cycle pulse: early frame-clock rise |

## Verification
The assertions take for granted that the bit clock is at most a quarter of the system clock, with each phase lasting at least two cycles. They also assume that the frame clock and the data line change only away from rising bit-clock edges. Without these conditions, samples could complete in adjacent cycles or a bit could be sampled while it is changing. The stimulus changes the frame clock and the data line only while the bit clock is low. It uses bit periods of eight system cycles, and four cycles for the fastest frame. Ready is held high, driven from a pseudo-random pattern, or held low for a whole frame, and it changes just after the clock edge.

// File: rtl/tdm_lsn_pkg.sv
package tdm_lsn_pkg;
  localparam int unsigned SLOTS_DEF    = 8;
  localparam int unsigned SAMPLE_W_DEF = 24;
  localparam int unsigned WORD_W_DEF   = 32;
  localparam int unsigned SYNC_N_DEF   = 2;
endpackage

// File: rtl/tdm_lsn_sync.sv
module tdm_lsn_sync #(
  parameter int unsigned N_BITS = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_BITS-1:0] din,
  output logic [N_BITS-1:0] dout
);
  logic [N_BITS-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/tdm_lsn_deser.sv
module tdm_lsn_deser #(
  parameter int unsigned SLOTS    = 8,
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned WORD_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_s,
  input  logic              fclk_s,
  input  logic              data_s,
  output logic              samp_vld,
  output logic [WORD_W-1:0] samp_word,
  output logic              samp_last,
  output logic              ferr
);
  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam int unsigned BIT_W  = $clog2(SAMPLE_W);

  logic              bclk_d, fclk_prev, armed, done;
  logic [SLOT_W-1:0] slot;
  logic [BIT_W-1:0]  bitc;
  logic [SAMPLE_W-2:0] shreg;
  logic bclk_rise, frame_edge, take_bit, last_bit, last_slot;
  logic [WORD_W-1:0] word_next;

  assign bclk_rise  = bclk_s & ~bclk_d;
  assign frame_edge = bclk_rise & fclk_s & ~fclk_prev;
  assign take_bit   = bclk_rise & armed & ~done;
  assign last_bit   = take_bit & (bitc == BIT_W'(SAMPLE_W-1));
  assign last_slot  = (slot == SLOT_W'(SLOTS-1));

  always_comb begin
    word_next = '0;
    word_next[SAMPLE_W-1:0] = {shreg, data_s};
    word_next[SAMPLE_W +: SLOT_W] = slot;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_d    <= 1'b0;
      fclk_prev <= 1'b0;
      armed     <= 1'b0;
      done      <= 1'b0;
      slot      <= '0;
      bitc      <= '0;
      shreg     <= '0;
      samp_vld  <= 1'b0;
      samp_word <= '0;
      samp_last <= 1'b0;
      ferr      <= 1'b0;
    end else begin
      samp_vld <= 1'b0;
      ferr     <= 1'b0;
      bclk_d   <= bclk_s;
      if (bclk_rise) fclk_prev <= fclk_s;
      if (take_bit) begin
        shreg <= {shreg[SAMPLE_W-3:0], data_s};
        if (last_bit) begin
          bitc      <= '0;
          samp_vld  <= 1'b1;
          samp_word <= word_next;
          samp_last <= last_slot;
          if (last_slot) begin
            done <= 1'b1;
            slot <= '0;
          end else begin
            slot <= slot + 1'b1;
          end
        end else begin
          bitc <= bitc + 1'b1;
        end
      end
      // a frame edge on the last bit of slot 7 is a clean boundary
      if (frame_edge) begin
        armed <= 1'b1;
        done  <= 1'b0;
        bitc  <= '0;
        slot  <= '0;
        if (armed && !done && !(last_bit && last_slot)) ferr <= 1'b1;
      end
    end
  end

  // R8: framing error is a single-cycle pulse
  p_ferr_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ferr |=> !ferr);

  // R10: with bit clock at most clk/4, samples never complete back to back
  p_samp_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    samp_vld |=> !samp_vld);
endmodule

// File: rtl/tdm_lsn_skid.sv
module tdm_lsn_skid #(
  parameter int unsigned W = 33
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_dat,
  output logic         out_vld,
  output logic [W-1:0] out_dat,
  input  logic         out_rdy,
  output logic         ovf
);
  logic [W-1:0] ent [2];
  logic         wp, rp;
  logic [1:0]   cnt;
  logic         pop, push, drop;

  assign out_vld = (cnt != 2'd0);
  assign out_dat = ent[rp];
  assign pop     = out_vld & out_rdy;
  assign push    = in_vld & ((cnt != 2'd2) | pop);
  assign drop    = in_vld & ~push;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent[0] <= '0;
      ent[1] <= '0;
      wp     <= 1'b0;
      rp     <= 1'b0;
      cnt    <= 2'd0;
      ovf    <= 1'b0;
    end else begin
      if (push) begin
        ent[wp] <= in_dat;
        wp      <= ~wp;
      end
      if (pop) rp <= ~rp;
      cnt <= cnt + {1'b0, push} - {1'b0, pop};
      if (drop) ovf <= 1'b1;
    end
  end

  // R5: an offered beat is held unchanged until accepted
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_rdy) |=> (out_vld && $stable(out_dat)));

  // R6: overflow flag is sticky
  p_no_overflow_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ovf) |-> ovf);

  // R6: occupancy never exceeds two entries
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != 2'd3);
endmodule

// File: rtl/tdm_bus_listener.sv
module tdm_bus_listener
  import tdm_lsn_pkg::*;
#(
  parameter int unsigned SLOTS    = SLOTS_DEF,
  parameter int unsigned SAMPLE_W = SAMPLE_W_DEF,
  parameter int unsigned WORD_W   = WORD_W_DEF,
  parameter int unsigned SYNC_N   = SYNC_N_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_bclk,
  input  logic              bus_fclk,
  input  logic              bus_data,
  output logic [WORD_W-1:0] m_tdata,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic              m_tlast,
  output logic              ovf_flag,
  output logic              frame_err
);
  localparam int unsigned SLOT_W = $clog2(SLOTS);

  logic [2:0]        sync_q;
  logic              samp_vld, samp_last;
  logic [WORD_W-1:0] samp_word;

  tdm_lsn_sync #(.N_BITS(3), .STAGES(SYNC_N)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({bus_bclk, bus_fclk, bus_data}),
    .dout (sync_q)
  );

  tdm_lsn_deser #(.SLOTS(SLOTS), .SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W)) u_deser (
    .clk      (clk),
    .rst_n    (rst_n),
    .bclk_s   (sync_q[2]),
    .fclk_s   (sync_q[1]),
    .data_s   (sync_q[0]),
    .samp_vld (samp_vld),
    .samp_word(samp_word),
    .samp_last(samp_last),
    .ferr     (frame_err)
  );

  tdm_lsn_skid #(.W(WORD_W + 1)) u_skid (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_vld (samp_vld),
    .in_dat ({samp_last, samp_word}),
    .out_vld(m_tvalid),
    .out_dat({m_tlast, m_tdata}),
    .out_rdy(m_tready),
    .ovf    (ovf_flag)
  );

  // R4: last flag coincides with the final slot index at the output
  p_last_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> (m_tlast == (m_tdata[SAMPLE_W +: SLOT_W] == SLOT_W'(SLOTS-1))));

  if (WORD_W > SAMPLE_W + SLOT_W) begin : g_pad_chk
    // R3: padding bits above the slot field stay zero
    p_pad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid |-> (m_tdata[WORD_W-1:SAMPLE_W+SLOT_W] == '0));
  end
endmodule

// File: tb/tdm_bus_listener_tb_top.sv
module tdm_bus_listener_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_bclk = 1'b0, bus_fclk = 1'b0, bus_data = 1'b0;
  logic        m_tready = 1'b1;
  logic [31:0] m_tdata;
  logic        m_tvalid, m_tlast, ovf_flag, frame_err;

  int errors = 0, checks = 0;
  int ferr_seen = 0, ferr_exp = 0;
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [32:0] exp_q[$];
  logic [32:0] got_q[$];
  logic        prev_v = 1'b0, prev_r = 1'b0;
  logic [32:0] prev_d = '0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  tdm_bus_listener dut_i (
    .clk(clk), .rst_n(rst_n), .bus_bclk(bus_bclk), .bus_fclk(bus_fclk),
    .bus_data(bus_data), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
    .m_tready(m_tready), .m_tlast(m_tlast), .ovf_flag(ovf_flag),
    .frame_err(frame_err)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ready driver, changed just after the active edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rdy_mode)
      0: m_tready = 1'b1;
      1: m_tready = lfsr[0] | lfsr[1];
      default: m_tready = 1'b0;
    endcase
  end

  // monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_err) ferr_seen++;
      if (prev_v && !prev_r)
        check(m_tvalid && ({m_tlast, m_tdata} == prev_d), "R5 hold",
              {31'd0, m_tlast, m_tdata}, {31'd0, prev_d});
      if (m_tvalid && m_tready) got_q.push_back({m_tlast, m_tdata});
      prev_v = m_tvalid;
      prev_r = m_tready;
      prev_d = {m_tlast, m_tdata};
    end
  end

  function automatic logic [23:0] samp_val(input int p, input int s);
    case (p)
      0: samp_val = 24'h000000;
      1: samp_val = 24'hFFFFFF;
      2: samp_val = 24'h000001 << ((s * 3 + 5) % 24);
      3: samp_val = 24'(s * 24'h13579 + 24'h5A5A5);
      4: samp_val = 24'hAAAAAA ^ 24'(s * 24'h010101);
      default: samp_val = 24'(s * 24'h2468B + p * 24'h0F0F1);
    endcase
  endfunction

  task automatic send_bit(input logic d, input logic f, input int half);
    @(negedge clk);
    bus_bclk = 1'b0;
    bus_fclk = f;
    bus_data = d;
    repeat (half) @(negedge clk);
    bus_bclk = 1'b1;
    repeat (half - 1) @(negedge clk);
  endtask

  // nsl slots; expected beats only for the first keep slots;
  // fend puts a frame-clock rise on the final bit
  task automatic send_frame(input int nsl, input int p, input int keep,
                            input bit fend, input int half);
    for (int s = 0; s < nsl; s++) begin
      logic [23:0] v;
      v = samp_val(p, s);
      if (s < keep) exp_q.push_back({(s == 7), 5'd0, 3'(s), v});
      for (int b = 23; b >= 0; b--)
        send_bit(v[b], fend && (s == nsl - 1) && (b == 0), half);
    end
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check(m_tvalid == 1'b0 && ovf_flag == 1'b0 && frame_err == 1'b0, "R1 reset outputs",
          {61'd0, m_tvalid, ovf_flag, frame_err}, 64'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(m_tvalid == 1'b0, "R1 idle after reset", {63'd0, m_tvalid}, 64'd0);

    // R9: garbage before the first frame-clock rise
    for (int i = 0; i < 10; i++) send_bit(i[0], 1'b0, 4);
    repeat (20) @(negedge clk);
    check(got_q.size() == 0, "R9 no beats before first frame", got_q.size(), 0);
    send_bit(1'b1, 1'b1, 4);

    // R2 R3 R4 sweep over data patterns, ready always high then random
    for (int p = 0; p < 5; p++) begin
      rdy_mode = (p >= 2) ? 1 : 0;
      send_frame(8, p, 8, 1'b1, 4);
    end
    rdy_mode = 0;

    // R9: frame with no trailing edge, idle bits, then a clean edge
    send_frame(8, 5, 8, 1'b0, 4);
    for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0, 4);
    send_bit(1'b1, 1'b1, 4);
    repeat (20) @(negedge clk);
    check(got_q.size() == exp_q.size(), "R9 idle bits ignored", got_q.size(), exp_q.size());
    check(ferr_seen == 0, "R8 no error on complete frames", ferr_seen, 0);

    // R8: early frame-clock rise after three slots
    send_frame(3, 3, 3, 1'b1, 4);
    ferr_exp = 1;
    repeat (10) @(negedge clk);
    check(ferr_seen == ferr_exp, "R8 early edge pulse", ferr_seen, ferr_exp);
    send_frame(8, 4, 8, 1'b1, 4);

    // R6: ready held low for a whole frame
    repeat (20) @(negedge clk);
    check(ovf_flag == 1'b0, "R6 no overflow yet", {63'd0, ovf_flag}, 64'd0);
    rdy_mode = 2;
    send_frame(8, 3, 2, 1'b1, 4);
    repeat (4) @(negedge clk);
    check(ovf_flag == 1'b1, "R6 overflow set", {63'd0, ovf_flag}, 64'd1);
    rdy_mode = 0;
    // R7: alignment kept after drops
    send_frame(8, 2, 8, 1'b1, 4);
    check(ovf_flag == 1'b1, "R6 overflow sticky", {63'd0, ovf_flag}, 64'd1);

    // R10: bit clock at a quarter of the system clock
    send_frame(8, 5, 8, 1'b0, 2);
    repeat (40) @(negedge clk);
    check(got_q.size() == exp_q.size(), "R10 fast frame beat count", got_q.size(), exp_q.size());
    check(ferr_seen == ferr_exp, "R8 total error pulses", ferr_seen, ferr_exp);

    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
      check(got_q[i][23:0] == exp_q[i][23:0], "R2 sample data",
            {40'd0, got_q[i][23:0]}, {40'd0, exp_q[i][23:0]});
      check(got_q[i][31:24] == exp_q[i][31:24], "R3 slot and pad field",
            {56'd0, got_q[i][31:24]}, {56'd0, exp_q[i][31:24]});
      check(got_q[i][32] == exp_q[i][32], "R4 last flag",
            {63'd0, got_q[i][32]}, {63'd0, exp_q[i][32]});
    end
    check(got_q.size() == exp_q.size(), "R7 total beats", got_q.size(), exp_q.size());
    finished = 1'b1;
    finish_run();
  end
endmodule